// File: doc/BRIEF.md
# Square-Channel Sweep Unit

This block drives the frequency glide of one square-wave voice in a console-style sound generator. It holds the voice's 11-bit timer period. On each half-frame strobe it can move that period up or down by a right-shifted copy of itself. It also raises a mute flag whenever the period is too short to sound, or whenever the next target would overflow past 11 bits.

Software programs the unit with one byte: an enable bit, a 3-bit divider period, a negate bit and a 3-bit shift count. Software loads the timer period directly through a separate write port.

A build-time parameter picks how the change amount is negated. Ones' complement suits the first square voice and two's complement suits the second. With negate set and a shift count of zero, both variants force the target to zero. This keeps the voice from muting on a false overflow.

Top module: `pulse_sweep`

## Requirements
- R1: The change amount is period_o shifted right by the shift count. With negate clear, the target is period_o plus the change amount, kept to 12 bits. An eligible half-frame tick loads target[10:0] into period_o.
- R2: With ONES_NEG=1 and negate set (shift nonzero), the target is period_o plus the bitwise inverse of the change amount in 12 bits. This equals period_o minus change minus 1.
- R3: With ONES_NEG=0 and negate set (shift nonzero), the target is period_o minus the change amount.
- R4: With negate set and a shift count of 0, the target is forced to 0 in both variants. This condition never raises mute_o while period_o is 8 or more.
- R5: mute_o is high while bit 11 of the target is set. It is evaluated continuously, whether or not sweep is enabled.
- R6: mute_o is high whenever period_o is less than 8.
- R7: A half-frame tick loads the target into period_o only when all four of these hold: the divider count is 0, enable is set, the shift is nonzero, and mute_o is low. Otherwise period_o holds.
- R8: On a half-frame tick, the divider reloads with the divider period if its count is 0 or the reload flag is set, and the reload flag clears. Otherwise the divider decrements. A sweep write sets the reload flag.
- R9: A period write loads period_data_i into period_o on the next edge. It takes priority over a sweep update in the same cycle.
- R10: The sweep byte layout is bit 7 enable, bits 6:4 divider period, bit 3 negate, and bits 2:0 shift count.
- R11: After reset, period_o is 0 and mute_o is 1. The divider count, the reload flag and the sweep settings are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sweep_wr_i | input | 1 | Sweep byte write strobe |
| sweep_data_i | input | 8 | Sweep byte (layout in R10) |
| period_wr_i | input | 1 | Timer period write strobe |
| period_data_i | input | PERIOD_W | Timer period write value |
| half_tick_i | input | 1 | Half-frame strobe, one cycle wide |
| period_o | output | PERIOD_W | Current timer period |
| mute_o | output | 1 | Voice mute flag |

## Verification
The assertions check, on every cycle, the following behaviours:
- the mute flag for short periods;
- the zero-shift negate case never muting;
- the period holding when there is no tick, sweep is disabled, or the voice is muted;
- a period write taking effect on the next edge.

The arithmetic of the two negation variants needs the bench's directed scenarios, which run both variants side by side. So do the overflow mute, the divider's every-N-ticks cadence and the reload that restarts a running divider. Each scenario computes its expected periods by hand from the requirements.

// File: rtl/pulse_sweep_pkg.sv
package pulse_sweep_pkg;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned SHIFT_W = 3;

  typedef struct packed {
    logic               en;
    logic [DIV_W-1:0]   div_per;
    logic               neg;
    logic [SHIFT_W-1:0] shift;
  } sweep_cfg_t;
endpackage

// File: rtl/sweep_target.sv
module sweep_target #(
  parameter int unsigned PERIOD_W = 11,
  parameter int unsigned SHIFT_W  = 3,
  parameter bit          ONES_NEG = 1'b1
) (
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  input  logic                neg_i,
  output logic [PERIOD_W:0]   target_o
);
  localparam int unsigned TW = PERIOD_W + 1;

  logic [TW-1:0] period_ext, change_ext, neg_change;

  assign period_ext = {1'b0, period_i};
  assign change_ext = {1'b0, period_i >> shift_i};

  generate
    if (ONES_NEG) begin : g_ones
      assign neg_change = ~change_ext;
    end else begin : g_twos
      assign neg_change = ~change_ext + TW'(1);
    end
  endgenerate

  always_comb begin
    if (!neg_i)                target_o = period_ext + change_ext;
    else if (shift_i == '0)    target_o = '0;  // avoid false overflow
    else                       target_o = period_ext + neg_change;
  end
endmodule

// File: rtl/sweep_divider.sv
module sweep_divider #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_set_i,
  input  logic [DIV_W-1:0] div_per_i,
  output logic             zero_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             reload_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      if (tick_i) begin
        if (zero_o || reload_q) cnt_q <= div_per_i;
        else                    cnt_q <= cnt_q - DIV_W'(1);
      end
      if (reload_set_i) reload_q <= 1'b1;
      else if (tick_i)  reload_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep
  import pulse_sweep_pkg::*;
#(
  parameter int unsigned PERIOD_W   = 11,
  parameter bit          ONES_NEG   = 1'b1,
  parameter int unsigned MIN_PERIOD = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sweep_wr_i,
  input  logic [7:0]          sweep_data_i,
  input  logic                period_wr_i,
  input  logic [PERIOD_W-1:0] period_data_i,
  input  logic                half_tick_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic                mute_o
);
  sweep_cfg_t          cfg_q;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W:0]   target;
  logic                div_zero, do_update;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= '0;
    else if (sweep_wr_i) cfg_q <= sweep_cfg_t'(sweep_data_i);
  end

  sweep_target #(
    .PERIOD_W(PERIOD_W), .SHIFT_W(SHIFT_W), .ONES_NEG(ONES_NEG)
  ) u_target (
    .period_i(period_q), .shift_i(cfg_q.shift), .neg_i(cfg_q.neg), .target_o(target)
  );

  sweep_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(half_tick_i),
    .reload_set_i(sweep_wr_i), .div_per_i(cfg_q.div_per), .zero_o(div_zero)
  );

  assign mute_o = (period_q < PERIOD_W'(MIN_PERIOD)) || target[PERIOD_W];

  assign do_update = half_tick_i && div_zero && cfg_q.en &&
                     (cfg_q.shift != '0) && !mute_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          period_q <= '0;
    else if (period_wr_i) period_q <= period_data_i;
    else if (do_update)   period_q <= target[PERIOD_W-1:0];
  end

  assign period_o = period_q;
endmodule

// File: rtl/pulse_sweep_chk.sv
module pulse_sweep_chk #(
  parameter int unsigned PERIOD_W   = 11,
  parameter int unsigned MIN_PERIOD = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                half_tick_i,
  input logic                period_wr_i,
  input logic [PERIOD_W-1:0] period_data_i,
  input logic [PERIOD_W-1:0] period_o,
  input logic                mute_o,
  input logic                en,
  input logic                neg,
  input logic [2:0]          shift
);
  a_r6_short_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o < PERIOD_W'(MIN_PERIOD)) |-> mute_o);

  a_r4_negzero_sounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg && shift == 3'd0 && period_o >= PERIOD_W'(MIN_PERIOD)) |-> !mute_o);

  a_r7_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_tick_i && !period_wr_i) |=> $stable(period_o));

  a_r7_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !period_wr_i) |=> $stable(period_o));

  a_r7_hold_muted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && !period_wr_i) |=> $stable(period_o));

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_wr_i |=> (period_o == $past(period_data_i)));
endmodule

bind pulse_sweep pulse_sweep_chk #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .half_tick_i(half_tick_i),
  .period_wr_i(period_wr_i), .period_data_i(period_data_i),
  .period_o(period_o), .mute_o(mute_o),
  .en(cfg_q.en), .neg(cfg_q.neg), .shift(cfg_q.shift)
);

// File: tb/pulse_sweep_bench.sv
module pulse_sweep_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sweep_wr = 1'b0, period_wr = 1'b0, tick = 1'b0;
  logic [7:0]  sweep_data = '0;
  logic [10:0] period_data = '0;
  logic [10:0] per1, per2;
  logic        mute1, mute2;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pulse_sweep #(.ONES_NEG(1'b1)) u_pulse_sweep (
    .clk_i(clk), .rst_ni(rst_n), .sweep_wr_i(sweep_wr), .sweep_data_i(sweep_data),
    .period_wr_i(period_wr), .period_data_i(period_data), .half_tick_i(tick),
    .period_o(per1), .mute_o(mute1));

  pulse_sweep #(.ONES_NEG(1'b0)) u_pulse_sweep_twos (
    .clk_i(clk), .rst_ni(rst_n), .sweep_wr_i(sweep_wr), .sweep_data_i(sweep_data),
    .period_wr_i(period_wr), .period_data_i(period_data), .half_tick_i(tick),
    .period_o(per2), .mute_o(mute2));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one-cycle pulses, driven and sampled on negedge
  task automatic wr_period(input int v);
    period_wr = 1'b1; period_data = 11'(v);
    @(negedge clk); period_wr = 1'b0;
  endtask
  task automatic wr_sweep(input logic [7:0] v);
    sweep_wr = 1'b1; sweep_data = v;
    @(negedge clk); sweep_wr = 1'b0;
  endtask
  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 period after reset", per1, 0);
    chk("R11 mute after reset", mute1, 1);
  endtask

  task automatic t_add();
    wr_period(200);
    wr_sweep(8'h81);  // en, div 0, shift 1 (R10)
    chk("R10 layout enable/shift, unmuted", mute1, 0);
    do_tick();
    chk("R1 add ones", per1, 300);
    chk("R1 add twos", per2, 300);
  endtask

  task automatic t_negate();
    wr_sweep(8'h8A);  // en, negate, shift 2
    do_tick();
    chk("R2 ones negate 300-75-1", per1, 224);
    chk("R3 twos negate 300-75", per2, 225);
  endtask

  task automatic t_negzero();
    wr_period(200);
    wr_sweep(8'h88);  // en, negate, shift 0
    chk("R4 ones no mute", mute1, 0);
    chk("R4 twos no mute", mute2, 0);
    do_tick();
    chk("R4 no update on zero shift", per1, 200);
  endtask

  task automatic t_overflow();
    wr_period(1536);
    wr_sweep(8'h81);
    chk("R5 overflow mutes", mute1, 1);
    do_tick();
    chk("R7 muted holds", per1, 1536);
    wr_sweep(8'h01);  // disabled, still overflow
    chk("R5 mute while disabled", mute1, 1);
  endtask

  task automatic t_small();
    wr_sweep(8'h00);
    wr_period(5);
    chk("R6 period 5 mutes", mute1, 1);
    wr_period(8);
    chk("R6 period 8 sounds", mute1, 0);
  endtask

  task automatic t_disabled();
    wr_period(400);
    wr_sweep(8'h01);
    do_tick();
    chk("R7 disabled holds", per1, 400);
  endtask

  task automatic t_divider();
    wr_period(256);
    wr_sweep(8'hA3);  // en, div 2, shift 3
    do_tick();
    chk("R8 first tick updates", per1, 288);
    do_tick();
    chk("R8 count 2 holds", per1, 288);
    do_tick();
    chk("R8 count 1 holds", per1, 288);
    do_tick();
    chk("R8 count 0 updates", per1, 324);
    do_tick();        // count 2 -> 1
    wr_sweep(8'hA3);  // reload flag
    do_tick();        // count 1, reload -> 2
    do_tick();        // 2 -> 1
    chk("R8 reload restarts divider", per1, 324);
    do_tick();        // 1 -> 0
    chk("R8 still counting", per1, 324);
    do_tick();
    chk("R8 update after reload", per1, 364);
  endtask

  task automatic t_write_wins();
    wr_sweep(8'h81);
    do_tick();        // settle divider to 0
    period_wr = 1'b1; period_data = 11'd100; tick = 1'b1;
    @(negedge clk); period_wr = 1'b0; tick = 1'b0;
    chk("R9 write beats tick", per1, 100);
    do_tick();
    chk("R9 tick after write", per1, 150);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_negate();
    t_negzero();
    t_overflow();
    t_small();
    t_disabled();
    t_divider();
    t_write_wins();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule